// File: doc/BRIEF.md
# Virtual channel and switch allocator

This block holds the allocation control for an input-buffered router with `P` ports and `V` virtual channels on each port. It runs two independent processes. Packet-level channel allocation binds a waiting head flit to a free virtual channel on the output port that route computation chose for it. Flit-level switch allocation then picks, every cycle, the flits that cross the crossbar: at most one per input port and at most one per output port. Flit buffers, the crossbar datapath and route computation sit outside the block. They present flags and route numbers for each input channel and read back the bindings and crossbar grants.

Each input channel has a two-state machine. In IDLE, a valid head flit requests channel allocation. On a grant, the *bind* transition moves it to ACTIVE and latches the output port and channel. In ACTIVE it competes for the switch. When its tail flit wins the switch, the *release* transition returns it to IDLE. Each output channel has a matching two-state machine. FREE moves to BUSY through the *claim* transition when it is handed to an input channel. BUSY moves back to FREE through the *free* transition when the owner's tail flit is granted. Channel `c` of port `p` has the global number `p*V + c`, and input channels use the same numbering.

The arbiters are round-robin with a pointer for each arbitration point. After a grant to index `k`, the pointer moves to `k+1`, wrapping around. The index at the pointer has the highest priority. All pointers start at 0.

Top module: `vcsa_top`

## Requirements
- R1: After reset, no input channel is bound, all output channels are free, and `va_grant`, `sw_grant` and `xbar_valid` are all zero.
- R2: An IDLE input channel with `in_valid` and `in_head` set, whose routed port has a free channel, can be granted in that same cycle. It receives the lowest-numbered free channel of that port on `va_vc`. From the next cycle on, `bound` is set and `bound_ovc` equals `port*V + vc`. The channel does not receive a switch grant in the cycle of its allocation.
- R3: Each output port grants at most one channel allocation per cycle, and different ports grant independently in the same cycle. Requesters of one port are served round-robin by input channel index, with a pointer that moves only when that port grants.
- R4: A head flit whose port has no free channel gets no grant and remains unbound until a channel frees.
- R5: An output channel stays owned from its allocation until the switch grant of its owner's tail flit (`in_tail`). The owner then becomes unbound and the channel can be granted from the next cycle, not in the release cycle.
- R6: A bound input channel requests the switch only while `in_valid` is set and `ovc_credit` of its own output channel is 1.
- R7: At most one channel of an input port receives `sw_grant` per cycle. Among requesting channels of the same port, a round-robin pointer over the channel number decides.
- R8: At most one input port wins each output port per cycle. Competing input ports are picked round-robin. `xbar_valid[o]` is set and `xbar_src[o]` names the winning input port.
- R9: Round-robin pointers move only on a final grant. A cycle with no grant, or an input-stage winner that loses at the output stage, leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | P*V | A flit is present at the head of each input channel |
| in_head | input | P*V | That flit is a head flit |
| in_tail | input | P*V | That flit is a tail flit |
| in_route | input | P*V*$clog2(P) | Output port computed for each input channel's packet |
| ovc_credit | input | P*V | Downstream buffer of each output channel has at least one credit |
| va_grant | output | P*V | Channel allocation granted this cycle |
| va_vc | output | P*V*$clog2(V) | Channel number within the port handed to each granted input |
| bound | output | P*V | Input channel holds an output channel |
| bound_ovc | output | P*V*$clog2(P*V) | Global number of the held output channel |
| sw_grant | output | P*V | Input channel sends its flit through the crossbar this cycle |
| xbar_valid | output | P | Output port is driven this cycle |
| xbar_src | output | P*$clog2(P) | Input port connected to each output port |

## Verification
The bench drives a 4-port, 2-channel configuration through hand-sequenced scenarios. Their expected grants come from stepping the round-robin pointers by hand. It fills a port's channels and checks that a further head waits. A design that leaked an unfree channel would grant here. It then releases a channel by its tail and checks that the freed channel is not handed out in the release cycle but is in the next one. A same-cycle hand-off would show up as an early grant. Credit removal for one and for both channels of a port checks that an uncredited channel never reaches the switch and that idle cycles do not move pointers. A pointer moved without a grant would pick the wrong channel on the following cycle. Two input ports alternating on one output, and a late requester that beats a lower-indexed one because the pointer has passed it, separate round-robin from fixed priority.

// File: rtl/vcsa_pkg.sv
package vcsa_pkg;
    typedef enum logic {IV_IDLE, IV_ACTIVE} iv_state_e;
    typedef enum logic {OV_FREE, OV_BUSY}   ov_state_e;
endpackage

// File: rtl/vcsa_rr_arb.sv
module vcsa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;

    always_comb begin
        int s;
        logic [IW-1:0] idx;
        logic hit;
        gnt = '0;
        win = '0;
        hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            s = int'(ptr) + k;
            if (s >= N) s = s - N;
            idx = IW'(s);
            if (!hit && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = idx;
                hit      = 1'b1;
            end
        end
    end

    // pointer moves past the winner, only on an accepted grant
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv && (|gnt))
            ptr <= (win == IW'(N-1)) ? '0 : win + 1'b1;
    end

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && (|gnt)) |=> $stable(ptr));
endmodule

// File: rtl/vcsa_vc_alloc.sv
module vcsa_vc_alloc #(
    parameter int P = 4,
    parameter int V = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [P*V-1:0]       va_req,
    input  logic [P*V*$clog2(P)-1:0] va_port,
    input  logic [P*V-1:0]       ovc_free,
    output logic [P*V-1:0]       va_gnt,
    output logic [P*V*$clog2(V)-1:0] va_vc
);
    localparam int NIVC = P * V;
    localparam int PW   = $clog2(P);
    localparam int VW   = $clog2(V);

    logic [VW-1:0]   low_vc   [P];
    logic [P-1:0]    any_free;
    logic [NIVC-1:0] port_req [P];
    logic [NIVC-1:0] port_gnt [P];

    // lowest free channel of each port, and requests per port
    always_comb begin
        for (int o = 0; o < P; o++) begin
            any_free[o] = 1'b0;
            low_vc[o]   = '0;
            for (int v = V - 1; v >= 0; v--) begin
                if (ovc_free[o*V + v]) begin
                    any_free[o] = 1'b1;
                    low_vc[o]   = VW'(v);
                end
            end
            for (int i = 0; i < NIVC; i++)
                port_req[o][i] = va_req[i] && any_free[o] &&
                                 (va_port[i*PW +: PW] == PW'(o));
        end
    end

    for (genvar o = 0; o < P; o++) begin : g_port
        vcsa_rr_arb #(.N(NIVC)) u_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (port_req[o]),
            .adv  (1'b1),
            .gnt  (port_gnt[o])
        );
    end

    always_comb begin
        va_gnt = '0;
        va_vc  = '0;
        for (int i = 0; i < NIVC; i++) begin
            for (int o = 0; o < P; o++) begin
                if (port_gnt[o][i]) begin
                    va_gnt[i]            = 1'b1;
                    va_vc[i*VW +: VW]    = low_vc[o];
                end
            end
        end
    end
endmodule

// File: rtl/vcsa_sw_alloc.sv
module vcsa_sw_alloc #(
    parameter int P = 4,
    parameter int V = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [P*V-1:0]           sw_req,
    input  logic [P*V*$clog2(P)-1:0] sw_port,
    output logic [P*V-1:0]           sw_gnt,
    output logic [P-1:0]             xb_valid,
    output logic [P*$clog2(P)-1:0]   xb_src
);
    localparam int PW = $clog2(P);

    logic [V-1:0]  in_req   [P];
    logic [V-1:0]  in_gnt   [P];
    logic [PW-1:0] sel_port [P];
    logic [P-1:0]  in_any;
    logic [P-1:0]  out_req  [P];
    logic [P-1:0]  out_gnt  [P];
    logic [P-1:0]  port_won;

    always_comb begin
        for (int p = 0; p < P; p++)
            in_req[p] = sw_req[p*V +: V];
    end

    // input stage: one candidate channel per input port
    for (genvar p = 0; p < P; p++) begin : g_in
        vcsa_rr_arb #(.N(V)) u_in_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (in_req[p]),
            .adv  (port_won[p]),
            .gnt  (in_gnt[p])
        );
    end

    always_comb begin
        for (int p = 0; p < P; p++) begin
            in_any[p]   = |in_gnt[p];
            sel_port[p] = '0;
            for (int v = 0; v < V; v++)
                if (in_gnt[p][v]) sel_port[p] = sw_port[(p*V + v)*PW +: PW];
        end
        for (int o = 0; o < P; o++)
            for (int p = 0; p < P; p++)
                out_req[o][p] = in_any[p] && (sel_port[p] == PW'(o));
    end

    // output stage: one input port per output port
    for (genvar o = 0; o < P; o++) begin : g_out
        vcsa_rr_arb #(.N(P)) u_out_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (out_req[o]),
            .adv  (1'b1),
            .gnt  (out_gnt[o])
        );
    end

    always_comb begin
        port_won = '0;
        xb_valid = '0;
        xb_src   = '0;
        for (int o = 0; o < P; o++) begin
            xb_valid[o] = |out_gnt[o];
            for (int p = 0; p < P; p++) begin
                if (out_gnt[o][p]) begin
                    port_won[p]            = 1'b1;
                    xb_src[o*PW +: PW]     = PW'(p);
                end
            end
        end
        for (int p = 0; p < P; p++)
            sw_gnt[p*V +: V] = port_won[p] ? in_gnt[p] : '0;
    end

    for (genvar p = 0; p < P; p++) begin : g_chk
        // R7
        one_per_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(sw_gnt[p*V +: V]));
    end
endmodule

// File: rtl/vcsa_top.sv
module vcsa_top
    import vcsa_pkg::*;
#(
    parameter  int P    = 4,
    parameter  int V    = 2,
    localparam int NIVC = P * V,
    localparam int PW   = $clog2(P),
    localparam int VW   = $clog2(V),
    localparam int OW   = $clog2(P * V)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIVC-1:0]    in_valid,
    input  logic [NIVC-1:0]    in_head,
    input  logic [NIVC-1:0]    in_tail,
    input  logic [NIVC*PW-1:0] in_route,
    input  logic [NIVC-1:0]    ovc_credit,
    output logic [NIVC-1:0]    va_grant,
    output logic [NIVC*VW-1:0] va_vc,
    output logic [NIVC-1:0]    bound,
    output logic [NIVC*OW-1:0] bound_ovc,
    output logic [NIVC-1:0]    sw_grant,
    output logic [P-1:0]       xbar_valid,
    output logic [P*PW-1:0]    xbar_src
);
    iv_state_e     iv_state_q [NIVC];
    iv_state_e     iv_state_d [NIVC];
    logic [PW-1:0] iv_port_q  [NIVC];
    logic [PW-1:0] iv_port_d  [NIVC];
    logic [VW-1:0] iv_vc_q    [NIVC];
    logic [VW-1:0] iv_vc_d    [NIVC];
    ov_state_e     ov_state_q [NIVC];
    ov_state_e     ov_state_d [NIVC];

    logic [OW-1:0]      held_ovc [NIVC];
    logic [OW-1:0]      new_ovc  [NIVC];
    logic [NIVC-1:0]    va_req;
    logic [NIVC-1:0]    sw_req;
    logic [NIVC*PW-1:0] sw_port;
    logic [NIVC-1:0]    ovc_free;
    logic [NIVC-1:0]    ovc_busy;

    always_comb begin
        for (int i = 0; i < NIVC; i++) begin
            held_ovc[i] = OW'(int'(iv_port_q[i]) * V + int'(iv_vc_q[i]));
            new_ovc[i]  = OW'(int'(in_route[i*PW +: PW]) * V + int'(va_vc[i*VW +: VW]));
            va_req[i]   = (iv_state_q[i] == IV_IDLE) && in_valid[i] && in_head[i];
            sw_req[i]   = (iv_state_q[i] == IV_ACTIVE) && in_valid[i] && ovc_credit[held_ovc[i]];
            sw_port[i*PW +: PW] = iv_port_q[i];
        end
        for (int o = 0; o < NIVC; o++) begin
            ovc_free[o] = (ov_state_q[o] == OV_FREE);
            ovc_busy[o] = (ov_state_q[o] == OV_BUSY);
        end
    end

    vcsa_vc_alloc #(.P(P), .V(V)) u_vc_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .va_req  (va_req),
        .va_port (in_route),
        .ovc_free(ovc_free),
        .va_gnt  (va_grant),
        .va_vc   (va_vc)
    );

    vcsa_sw_alloc #(.P(P), .V(V)) u_sw_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_req  (sw_req),
        .sw_port (sw_port),
        .sw_gnt  (sw_grant),
        .xb_valid(xbar_valid),
        .xb_src  (xbar_src)
    );

    // next state: bind / release on inputs, claim / free on outputs
    always_comb begin
        for (int o = 0; o < NIVC; o++)
            ov_state_d[o] = ov_state_q[o];
        for (int i = 0; i < NIVC; i++) begin
            iv_state_d[i] = iv_state_q[i];
            iv_port_d[i]  = iv_port_q[i];
            iv_vc_d[i]    = iv_vc_q[i];
            unique case (iv_state_q[i])
                IV_IDLE: begin
                    if (va_grant[i]) begin
                        iv_state_d[i]          = IV_ACTIVE;
                        iv_port_d[i]           = in_route[i*PW +: PW];
                        iv_vc_d[i]             = va_vc[i*VW +: VW];
                        ov_state_d[new_ovc[i]] = OV_BUSY;
                    end
                end
                IV_ACTIVE: begin
                    if (sw_grant[i] && in_tail[i]) begin
                        iv_state_d[i]           = IV_IDLE;
                        ov_state_d[held_ovc[i]] = OV_FREE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NIVC; i++) begin
            if (!rst_n) begin
                iv_state_q[i] <= IV_IDLE;
                iv_port_q[i]  <= '0;
                iv_vc_q[i]    <= '0;
                ov_state_q[i] <= OV_FREE;
            end else begin
                iv_state_q[i] <= iv_state_d[i];
                iv_port_q[i]  <= iv_port_d[i];
                iv_vc_q[i]    <= iv_vc_d[i];
                ov_state_q[i] <= ov_state_d[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NIVC; i++) begin
            bound[i]                = (iv_state_q[i] == IV_ACTIVE);
            bound_ovc[i*OW +: OW]   = bound[i] ? held_ovc[i] : '0;
        end
    end

    // R5
    owner_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ovc_busy) == $countones(bound));

    // R8
    xbar_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(xbar_valid) == $countones(sw_grant));

    for (genvar i = 0; i < NIVC; i++) begin : g_chk
        // R2
        grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            va_grant[i] |-> ovc_free[new_ovc[i]]);
        // R5
        tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_grant[i] && in_tail[i]) |=> !bound[i]);
        // R6
        credit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sw_grant[i] |-> (bound[i] && in_valid[i] && ovc_credit[held_ovc[i]]));
    end
endmodule

// File: tb/test_vcsa_top.sv
module test_vcsa_top;
    localparam int P  = 4;
    localparam int V  = 2;
    localparam int NI = P * V;
    localparam int PW = 2;
    localparam int VW = 1;
    localparam int OW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic [NI-1:0]    in_valid, in_head, in_tail, ovc_credit;
    logic [NI*PW-1:0] in_route;
    logic [NI-1:0]    va_grant, bound, sw_grant;
    logic [NI*VW-1:0] va_vc;
    logic [NI*OW-1:0] bound_ovc;
    logic [P-1:0]     xbar_valid;
    logic [P*PW-1:0]  xbar_src;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    vcsa_top #(.P(P), .V(V)) i_vcsa_top (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
        .in_route(in_route), .ovc_credit(ovc_credit),
        .va_grant(va_grant), .va_vc(va_vc), .bound(bound), .bound_ovc(bound_ovc),
        .sw_grant(sw_grant), .xbar_valid(xbar_valid), .xbar_src(xbar_src)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic pkt(input int i, input bit v, input bit h, input bit t, input int r);
        in_valid[i] = v;
        in_head[i]  = h;
        in_tail[i]  = t;
        in_route[i*PW +: PW] = PW'(r);
    endtask

    function automatic logic [31:0] vc_of(input int i);
        return 32'(va_vc[i*VW +: VW]);
    endfunction

    function automatic logic [31:0] ovc_of(input int i);
        return 32'(bound_ovc[i*OW +: OW]);
    endfunction

    function automatic logic [31:0] src_of(input int o);
        return 32'(xbar_src[o*PW +: PW]);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = '0; in_head = '0; in_tail = '0; in_route = '0;
        ovc_credit = '1;
        repeat (3) tick();
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 bound", 32'(bound), 0);
        chk("R1 va_grant", 32'(va_grant), 0);
        chk("R1 sw_grant", 32'(sw_grant), 0);
        chk("R1 xbar_valid", 32'(xbar_valid), 0);
        tick();

        // single-flit packet, input 0 to port 2
        pkt(0, 1, 1, 1, 2);
        settle();
        chk("R2 va_grant", 32'(va_grant), 32'h01);
        chk("R2 va_vc", vc_of(0), 0);
        chk("R2 no switch in alloc cycle", 32'(sw_grant), 0);
        tick();
        settle();
        chk("R2 bound", 32'(bound), 32'h01);
        chk("R2 bound_ovc", ovc_of(0), 4);
        chk("R6 sw_grant", 32'(sw_grant), 32'h01);
        chk("R8 xbar_valid", 32'(xbar_valid), 32'h4);
        chk("R8 xbar_src", src_of(2), 0);
        tick();
        pkt(0, 0, 0, 0, 0);
        settle();
        chk("R5 released after tail", 32'(bound), 0);

        // fill port 3 with inputs 2 and 3
        pkt(2, 1, 1, 0, 3);
        settle();
        chk("R2 va_grant in2", 32'(va_grant), 32'h04);
        chk("R2 lowest vc in2", vc_of(2), 0);
        tick();
        pkt(2, 0, 0, 0, 3);
        pkt(3, 1, 1, 0, 3);
        settle();
        chk("R2 va_grant in3", 32'(va_grant), 32'h08);
        chk("R2 next free vc in3", vc_of(3), 1);
        tick();
        pkt(3, 0, 0, 0, 3);
        pkt(4, 1, 1, 0, 3);
        settle();
        chk("R4 no free channel", 32'(va_grant), 0);
        chk("R2 bound in2 in3", 32'(bound), 32'h0C);
        chk("R2 bound_ovc in3", ovc_of(3), 7);
        tick();

        // input-stage round robin on port 1
        pkt(2, 1, 0, 0, 3);
        pkt(3, 1, 0, 0, 3);
        settle();
        chk("R7 first pick", 32'(sw_grant), 32'h04);
        chk("R8 src port1", src_of(3), 1);
        chk("R4 still waiting", 32'(va_grant), 0);
        tick();
        settle();
        chk("R7 second pick", 32'(sw_grant), 32'h08);
        tick();
        ovc_credit[6] = 1'b0;
        settle();
        chk("R6 no credit skips in2", 32'(sw_grant), 32'h08);
        tick();
        ovc_credit[6] = 1'b1;
        settle();
        chk("R7 back to in2", 32'(sw_grant), 32'h04);
        tick();
        ovc_credit[6] = 1'b0;
        ovc_credit[7] = 1'b0;
        settle();
        chk("R6 no credit no grant", 32'(sw_grant), 0);
        chk("R6 no credit no xbar", 32'(xbar_valid), 0);
        tick();
        ovc_credit = '1;
        settle();
        chk("R9 pointer held over idle cycle", 32'(sw_grant), 32'h08);
        tick();
        pkt(2, 1, 0, 1, 3);
        pkt(3, 0, 0, 0, 3);
        settle();
        chk("R5 tail grant", 32'(sw_grant), 32'h04);
        chk("R5 no reuse in release cycle", 32'(va_grant), 0);
        tick();
        pkt(2, 0, 0, 0, 3);
        settle();
        chk("R5 freed channel granted", 32'(va_grant), 32'h10);
        chk("R5 freed vc number", vc_of(4), 0);
        chk("R5 in2 unbound", 32'(bound), 32'h08);
        tick();

        // output-stage round robin: ports 1 and 2 on output 3
        pkt(4, 1, 0, 0, 3);
        pkt(3, 1, 0, 0, 3);
        settle();
        chk("R2 bound_ovc in4", ovc_of(4), 6);
        chk("R8 port2 wins", 32'(sw_grant), 32'h10);
        chk("R8 src port2", src_of(3), 2);
        tick();
        settle();
        chk("R8 port1 wins", 32'(sw_grant), 32'h08);
        chk("R8 src port1 again", src_of(3), 1);
        tick();
        settle();
        chk("R8 port2 again", 32'(sw_grant), 32'h10);
        tick();

        // two ports allocated in the same cycle, then one flit per input port
        pkt(3, 0, 0, 0, 3);
        pkt(4, 0, 0, 0, 3);
        pkt(0, 1, 1, 0, 0);
        pkt(1, 1, 1, 0, 1);
        settle();
        chk("R3 independent ports", 32'(va_grant), 32'h03);
        chk("R3 vc in0", vc_of(0), 0);
        chk("R3 vc in1", vc_of(1), 0);
        tick();
        pkt(0, 1, 0, 0, 0);
        pkt(1, 1, 0, 0, 1);
        settle();
        chk("R7 one per input in1", 32'(sw_grant), 32'h02);
        chk("R7 xbar out1", 32'(xbar_valid), 32'h2);
        chk("R8 src out1", src_of(1), 0);
        tick();
        settle();
        chk("R7 one per input in0", 32'(sw_grant), 32'h01);
        chk("R7 xbar out0", 32'(xbar_valid), 32'h1);
        tick();

        // allocation contention on port 2
        pkt(0, 0, 0, 0, 0);
        pkt(1, 0, 0, 0, 1);
        pkt(5, 1, 1, 0, 2);
        pkt(6, 1, 1, 0, 2);
        settle();
        chk("R3 one per port", 32'(va_grant), 32'h20);
        chk("R3 vc in5", vc_of(5), 0);
        tick();
        pkt(5, 0, 0, 0, 2);
        settle();
        chk("R3 second requester", 32'(va_grant), 32'h40);
        chk("R3 vc in6", vc_of(6), 1);
        tick();
        pkt(6, 0, 0, 0, 2);
        pkt(7, 1, 1, 0, 2);
        settle();
        chk("R4 port2 full", 32'(va_grant), 0);
        chk("R2 bound set", 32'(bound), 32'h7B);
        chk("R2 bound_ovc in6", ovc_of(6), 5);
        tick();
        pkt(5, 1, 0, 1, 2);
        settle();
        chk("R5 tail of in5", 32'(sw_grant), 32'h20);
        chk("R4 still no grant", 32'(va_grant), 0);
        tick();
        pkt(5, 0, 0, 0, 2);
        pkt(2, 1, 1, 0, 2);
        settle();
        chk("R3 pointer beats lower index", 32'(va_grant), 32'h80);
        chk("R3 vc in7", vc_of(7), 0);
        tick();
        pkt(7, 0, 0, 0, 2);
        settle();
        chk("R4 in2 waits", 32'(va_grant), 0);
        chk("R4 in2 unbound", 32'(bound[2]), 0);
        tick();

        done = 1'b1;
        finish_run();
    end
endmodule